// File: doc/BRIEF.md
# Double-Buffered Serial-Configured Crossbar Switch

This block is a 32-input by 32-output single-bit crossbar. Each output either follows one chosen input or is switched off. In the off state it drives a constant 0. The data path contains no registers, so a routed input reaches its output within the same cycle.

Routing is programmed through two independent serial ports, and both run inside the system clock domain. One port shifts in a 5-bit output index. The other shifts in a 6-bit route word, which holds an enable flag and a 5-bit input index. A falling edge on an active-low write strobe stores the route word into the shadow entry for the chosen output.

Shadow entries have no effect on the data path until an active-low commit strobe goes low. While it is low, every shadow entry is copied at once into the active table that steers the multiplexers. This lets any number of outputs be re-routed in a single cycle. If the commit strobe is held low, the active table tracks each write as soon as it lands.

Top module: `xbar_switch`

## Requirements
- R1: After reset every shadow and active entry is zero, so all 32 outputs are disabled and drive 0 whatever the inputs carry.
- R2: An output whose active entry has the enable flag (route word bit 5) at 0 drives 0.
- R3: An output whose active entry has the enable flag at 1 equals the input numbered by route word bits 4..0, in the same cycle and with no register in between.
- R4: The output index is shifted in on each synchronized rising edge of `idx_sclk`, taking `idx_sdata`. The most significant bit comes first, and the fifth bit shifted is bit 0.
- R5: The route word is shifted in on each synchronized rising edge of `rte_sclk`, taking `rte_sdata`. The enable flag (bit 5) comes first, followed by bits 4 down to 0.
- R6: Each synchronized falling edge of `wr_n` writes the current route word into the shadow entry chosen by the current output index. No other shadow entry changes.
- R7: While `commit_n` is high, writes to shadow entries leave the active table and every output unchanged.
- R8: While `commit_n` is low, every active entry is loaded from its shadow entry in the same clock cycle, so all re-routed outputs change together.
- R9: While `commit_n` is held low, a write strobe alters the addressed output's routing without any further commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 32 | Crossbar data inputs |
| data_out | output | 32 | Crossbar data outputs |
| idx_sclk | input | 1 | Serial clock for the output index register |
| idx_sdata | input | 1 | Serial data for the output index register |
| rte_sclk | input | 1 | Serial clock for the route word register |
| rte_sdata | input | 1 | Serial data for the route word register |
| wr_n | input | 1 | Active-low write strobe into the shadow table |
| commit_n | input | 1 | Active-low commit strobe, shadow to active; held low it makes the active table transparent |

## Verification
The crossbar is checked under several input patterns:
- All ones, which shows up any enabled output that fails to pass a 1.
- All zeros, which exposes a stuck-high output.
- Random words, which separate one input index from another, so a swapped bit or a reversed shift order in the serial registers appears as a wrong source bit.

Two random maps with mixed enable flags show the difference between disabled outputs (held at 0) and routed ones. Outputs are sampled after each shadow write and before the commit, which shows whether a write leaks through early. Outputs are sampled again after the commit, which shows whether all entries moved together. A final phase holds the commit strobe low and checks that single writes take effect at once.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;

    localparam int PORTS  = 32;
    localparam int IDX_W  = $clog2(PORTS);
    localparam int WORD_W = IDX_W + 1;
    localparam int TBL_W  = PORTS * WORD_W;

    // Synchronized pin positions and their idle levels
    localparam int PIN_IDX_CLK = 0;
    localparam int PIN_IDX_DAT = 1;
    localparam int PIN_RTE_CLK = 2;
    localparam int PIN_RTE_DAT = 3;
    localparam int PIN_WR_N    = 4;
    localparam int PIN_COMMIT_N = 5;
    localparam int PIN_COUNT   = 6;
    localparam logic [PIN_COUNT-1:0] PIN_IDLE = 6'b110000;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] src;
    } route_t;

    function automatic route_t entry_of(input logic [TBL_W-1:0] tbl, input int unsigned n);
        return route_t'(tbl[n*WORD_W +: WORD_W]);
    endfunction

    function automatic logic route_bit(input route_t r, input logic [PORTS-1:0] din);
        return r.en & din[r.src];
    endfunction

endpackage

// File: rtl/xbar_pin_sync.sv
module xbar_pin_sync #(
    parameter int               WIDTH  = 6,
    parameter int               STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE   = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= IDLE;
        end else begin
            stage_q[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign lvl_o = stage_q[STAGES-1];
endmodule

// File: rtl/xbar_serial_loader.sv
module xbar_serial_loader
    import xbar_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_clk_lvl,
    input  logic              idx_dat_lvl,
    input  logic              rte_clk_lvl,
    input  logic              rte_dat_lvl,
    input  logic              wr_n_lvl,
    output logic [IDX_W-1:0]  idx_o,
    output logic [WORD_W-1:0] word_o,
    output logic              idx_step_o,
    output logic              rte_step_o,
    output logic              wr_pulse_o
);
    logic idx_clk_q, rte_clk_q, wr_n_q;

    assign idx_step_o = idx_clk_lvl & ~idx_clk_q;
    assign rte_step_o = rte_clk_lvl & ~rte_clk_q;
    assign wr_pulse_o = ~wr_n_lvl & wr_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_clk_q <= 1'b0;
            rte_clk_q <= 1'b0;
            wr_n_q    <= 1'b1;
            idx_o     <= '0;
            word_o    <= '0;
        end else begin
            idx_clk_q <= idx_clk_lvl;
            rte_clk_q <= rte_clk_lvl;
            wr_n_q    <= wr_n_lvl;
            // First bit in ends up in the top position after a full load
            if (idx_step_o) idx_o  <= {idx_o[IDX_W-2:0], idx_dat_lvl};
            if (rte_step_o) word_o <= {word_o[WORD_W-2:0], rte_dat_lvl};
        end
    end
endmodule

// File: rtl/xbar_cfg_store.sv
module xbar_cfg_store
    import xbar_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_pulse_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              commit_n_lvl,
    output logic [TBL_W-1:0]  shadow_o,
    output logic [TBL_W-1:0]  active_o
);
    route_t shadow_q  [PORTS];
    route_t active_q  [PORTS];
    route_t shadow_nx [PORTS];

    always_comb begin
        for (int n = 0; n < PORTS; n++) shadow_nx[n] = shadow_q[n];
        if (wr_pulse_i) shadow_nx[idx_i] = route_t'(word_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < PORTS; n++) begin
                shadow_q[n] <= '0;
                active_q[n] <= '0;
            end
        end else begin
            for (int n = 0; n < PORTS; n++) begin
                shadow_q[n] <= shadow_nx[n];
                if (!commit_n_lvl) active_q[n] <= shadow_nx[n];
            end
        end
    end

    for (genvar g = 0; g < PORTS; g++) begin : g_flat
        assign shadow_o[g*WORD_W +: WORD_W] = shadow_q[g];
        assign active_o[g*WORD_W +: WORD_W] = active_q[g];
    end
endmodule

// File: rtl/xbar_route_mux.sv
module xbar_route_mux
    import xbar_cfg_pkg::*;
(
    input  logic [TBL_W-1:0] active_i,
    input  logic [PORTS-1:0] data_i,
    output logic [PORTS-1:0] data_o
);
    for (genvar g = 0; g < PORTS; g++) begin : g_out
        assign data_o[g] = route_bit(entry_of(active_i, g), data_i);
    end
endmodule

// File: rtl/xbar_switch.sv
module xbar_switch
    import xbar_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PORTS-1:0] data_in,
    output logic [PORTS-1:0] data_out,
    input  logic             idx_sclk,
    input  logic             idx_sdata,
    input  logic             rte_sclk,
    input  logic             rte_sdata,
    input  logic             wr_n,
    input  logic             commit_n
);
    logic [PIN_COUNT-1:0] pin_raw, pin_lvl;
    logic [IDX_W-1:0]     idx_q;
    logic [WORD_W-1:0]    word_q;
    logic                 idx_step, rte_step, wr_pulse, commit_low;
    logic [TBL_W-1:0]     shadow_tbl, active_tbl;

    always_comb begin
        pin_raw               = '0;
        pin_raw[PIN_IDX_CLK]  = idx_sclk;
        pin_raw[PIN_IDX_DAT]  = idx_sdata;
        pin_raw[PIN_RTE_CLK]  = rte_sclk;
        pin_raw[PIN_RTE_DAT]  = rte_sdata;
        pin_raw[PIN_WR_N]     = wr_n;
        pin_raw[PIN_COMMIT_N] = commit_n;
    end

    xbar_pin_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
        .clk(clk), .rst(rst), .pin_i(pin_raw), .lvl_o(pin_lvl)
    );

    assign commit_low = ~pin_lvl[PIN_COMMIT_N];

    xbar_serial_loader u_loader (
        .clk(clk), .rst(rst),
        .idx_clk_lvl(pin_lvl[PIN_IDX_CLK]), .idx_dat_lvl(pin_lvl[PIN_IDX_DAT]),
        .rte_clk_lvl(pin_lvl[PIN_RTE_CLK]), .rte_dat_lvl(pin_lvl[PIN_RTE_DAT]),
        .wr_n_lvl(pin_lvl[PIN_WR_N]),
        .idx_o(idx_q), .word_o(word_q),
        .idx_step_o(idx_step), .rte_step_o(rte_step), .wr_pulse_o(wr_pulse)
    );

    xbar_cfg_store u_store (
        .clk(clk), .rst(rst), .wr_pulse_i(wr_pulse), .idx_i(idx_q), .word_i(word_q),
        .commit_n_lvl(pin_lvl[PIN_COMMIT_N]),
        .shadow_o(shadow_tbl), .active_o(active_tbl)
    );

    xbar_route_mux u_mux (
        .active_i(active_tbl), .data_i(data_in), .data_o(data_out)
    );
endmodule

// File: rtl/xbar_switch_chk.sv
module xbar_switch_chk
    import xbar_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              idx_step,
    input logic              rte_step,
    input logic              wr_pulse,
    input logic              commit_low,
    input logic [IDX_W-1:0]  idx_q,
    input logic [WORD_W-1:0] word_q,
    input logic [TBL_W-1:0]  shadow_tbl,
    input logic [TBL_W-1:0]  active_tbl,
    input logic [PORTS-1:0]  data_in,
    input logic [PORTS-1:0]  data_out
);
    AST_IDX_SHIFT: assert property (@(posedge clk) disable iff (rst)
        idx_step |=> idx_q[IDX_W-1:1] == $past(idx_q[IDX_W-2:0])); // R4
    AST_WORD_SHIFT: assert property (@(posedge clk) disable iff (rst)
        rte_step |=> word_q[WORD_W-1:1] == $past(word_q[WORD_W-2:0])); // R5
    AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> shadow_tbl[$past(idx_q)*WORD_W +: WORD_W] == $past(word_q)); // R6
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_pulse |=> $stable(shadow_tbl)); // R6
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit_low |=> $stable(active_tbl)); // R7
    AST_ACTIVE_COPY: assert property (@(posedge clk) disable iff (rst)
        (commit_low && !wr_pulse) |=> active_tbl == shadow_tbl); // R8
    AST_TRANSPARENT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (commit_low && wr_pulse) |=> active_tbl[$past(idx_q)*WORD_W +: WORD_W] == $past(word_q)); // R9

    for (genvar g = 0; g < PORTS; g++) begin : g_out
        AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
            !active_tbl[g*WORD_W + IDX_W] |-> !data_out[g]); // R2
        AST_ROUTE_PASS: assert property (@(posedge clk) disable iff (rst)
            active_tbl[g*WORD_W + IDX_W] |-> data_out[g] == data_in[active_tbl[g*WORD_W +: IDX_W]]); // R3
    end
endmodule

bind xbar_switch xbar_switch_chk u_chk (
    .clk(clk), .rst(rst), .idx_step(idx_step), .rte_step(rte_step), .wr_pulse(wr_pulse),
    .commit_low(commit_low), .idx_q(idx_q), .word_q(word_q), .shadow_tbl(shadow_tbl),
    .active_tbl(active_tbl), .data_in(data_in), .data_out(data_out)
);

// File: tb/test_xbar_switch.sv
module test_xbar_switch;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] data_in = '0;
    logic [31:0] data_out;
    logic idx_sclk = 0, idx_sdata = 0, rte_sclk = 0, rte_sdata = 0, wr_n = 1, commit_n = 1;

    int n_vec = 0, n_bad = 0;
    logic       exp_en_sh [32], exp_en_act [32];
    logic [4:0] exp_src_sh [32], exp_src_act [32];
    bit         transparent = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    xbar_switch i_xbar_switch (
        .clk(clk), .rst(rst), .data_in(data_in), .data_out(data_out),
        .idx_sclk(idx_sclk), .idx_sdata(idx_sdata), .rte_sclk(rte_sclk), .rte_sdata(rte_sdata),
        .wr_n(wr_n), .commit_n(commit_n)
    );

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] model(input logic [31:0] din);
        logic [31:0] r = '0;
        for (int o = 0; o < 32; o++) r[o] = exp_en_act[o] & din[exp_src_act[o]];
        return r;
    endfunction

    task automatic check_pattern(input string req, input logic [31:0] din);
        logic [31:0] exp;
        data_in = din;
        #1;
        exp = model(din);
        n_vec++;
        if (data_out !== exp) begin
            n_bad++;
            $display("FAIL %s: data_in=%h data_out=%h expected=%h", req, din, data_out, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check_pattern(req, 32'hFFFF_FFFF);
        check_pattern(req, 32'h0000_0000);
        for (int k = 0; k < 3; k++) check_pattern(req, $urandom);
    endtask

    task automatic send_idx(input logic [4:0] a);
        for (int i = 4; i >= 0; i--) begin   // R4: MSB first
            idx_sdata = a[i]; hold(3);
            idx_sclk = 1;     hold(4);
            idx_sclk = 0;     hold(3);
        end
    endtask

    task automatic send_word(input logic en, input logic [4:0] src);
        logic [5:0] w = {en, src};
        for (int i = 5; i >= 0; i--) begin   // R5: enable flag first
            rte_sdata = w[i]; hold(3);
            rte_sclk = 1;     hold(4);
            rte_sclk = 0;     hold(3);
        end
    endtask

    task automatic write_entry(input logic [4:0] o, input logic en, input logic [4:0] src);
        send_idx(o);
        send_word(en, src);
        wr_n = 0; hold(4);
        wr_n = 1; hold(4);
        exp_en_sh[o] = en; exp_src_sh[o] = src;
        if (transparent) begin
            exp_en_act[o] = en; exp_src_act[o] = src;
        end
    endtask

    task automatic commit();
        commit_n = 0; hold(4);
        commit_n = 1; hold(4);
        for (int o = 0; o < 32; o++) begin
            exp_en_act[o] = exp_en_sh[o]; exp_src_act[o] = exp_src_sh[o];
        end
    endtask

    task automatic t_reset();
        for (int o = 0; o < 32; o++) begin
            exp_en_sh[o] = 0; exp_src_sh[o] = '0; exp_en_act[o] = 0; exp_src_act[o] = '0;
        end
        check_outputs("R1 reset all outputs off");
    endtask

    task automatic t_bit_order();
        // R4/R5: asymmetric index and source values expose reversed shift order
        write_entry(5'd1, 1'b1, 5'd30);
        write_entry(5'd16, 1'b1, 5'd3);
        check_outputs("R7 staged writes hidden");
        commit();
        check_outputs("R4 R5 bit order");
    endtask

    task automatic t_full_map();
        for (int o = 0; o < 32; o++) begin
            write_entry(o[4:0], ($urandom % 4) != 0, 5'($urandom));
            if (o % 8 == 7) check_outputs("R7 no change before commit");
        end
        commit();
        check_outputs("R8 R3 R2 simultaneous commit");
    endtask

    task automatic t_partial_map();
        write_entry(5'd0, 1'b0, 5'd0);
        write_entry(5'd31, 1'b1, 5'd0);
        write_entry(5'd7, 1'b1, 5'd31);
        write_entry(5'd7, 1'b1, 5'd12);   // R6: rewrite same entry
        check_outputs("R7 partial staged");
        commit();
        check_outputs("R6 R8 partial commit");
    endtask

    task automatic t_transparent();
        commit_n = 0; hold(4);
        transparent = 1;
        for (int o = 0; o < 32; o++) begin
            exp_en_act[o] = exp_en_sh[o]; exp_src_act[o] = exp_src_sh[o];
        end
        write_entry(5'd9, 1'b1, 5'd21);
        check_outputs("R9 transparent write");
        write_entry(5'd21, 1'b0, 5'd9);
        check_outputs("R9 R2 transparent disable");
        write_entry(5'd2, 1'b1, 5'd2);
        check_outputs("R9 R3 transparent route");
        commit_n = 1; hold(4);
        transparent = 0;
        write_entry(5'd9, 1'b0, 5'd0);
        check_outputs("R7 after leaving transparent");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        hold(4);
        rst = 0;
        hold(2);
        t_reset();
        t_bit_order();
        t_full_map();
        t_partial_map();
        t_transparent();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
        finish_run();
    end
endmodule